// File: doc/BRIEF.md
# Four-Channel Pulse Counter Controller

The block holds four independent up-counters that tally rising edges on asynchronous count inputs. A single 16-bit control word, written through a data bus with a write strobe, carries one 4-bit field per channel. Each field can zero that channel's count, hold it, block its external zeroing input, or clear the channel and end its pulse-output activity.

Two channels (0 and 2) also have an external reset input. On these channels a rising edge zeroes the count. While the channel is in pulse-output mode, the same edge is read as a home-position marker instead and latches a flag. A separate start input marks a channel as running pulse output. Generating the pulse waveforms themselves is done elsewhere.

Top module: `fastcnt_ctrl`

## Requirements
- R1: Channel i is governed by bits 4i+3..4i of the control word. A write acts on every channel at once, and a field of 0 on one channel leaves that channel's count unchanged.
- R2: Field bit 0 set zeroes the count in the clock cycle after the write cycle. It is a one-shot: counting resumes afterwards without a rewrite.
- R3: Each count is 24 bits wide and rises by one for each rising edge of its count input. The input passes through a two-flop synchronizer, so the new value is visible after the third rising clock edge that follows the input edge. The count wraps to zero on overflow.
- R4: Field bit 1 set to 1 stops counting on that channel. It is a level and stays in effect until the control word is rewritten.
- R5: On channels 0 and 2, outside pulse-output mode, a rising edge on the external reset input zeroes the count while field bit 2 is 0. Input bit 0 belongs to channel 0 and input bit 1 to channel 2.
- R6: Field bit 2 set to 1 is a level that makes the external reset input ignored. On channels 1 and 3, which have no such input, the bit changes nothing.
- R7: Field bit 3 set zeroes the count, drops the pulse-output-active flag and drops the home flag, all in the cycle after the write. Code 0x9 does the same as 0x8.
- R8: A start pulse sets the channel's pulse-output-active flag in the next cycle. A clear written in the same cycle wins, and the flag stays low.
- R9: In pulse-output mode, an external reset edge sets the channel's home flag and leaves the count unchanged. Channels 1 and 3 never raise a home flag.
- R10: A software reset or clear overrides a count edge in the same cycle. An external reset overrides a count edge in the same cycle.
- R11: After reset, all counts and flags are 0, and the stored levels have counting and the external reset enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word, 4 bits per channel |
| cnt_in | input | 4 | Asynchronous count inputs, one per channel |
| ext_rst_in | input | 2 | Asynchronous external reset inputs for channels 0 and 2 |
| pout_start | input | 4 | Pulse-output start pulses, one per channel |
| count_o | output | 96 | Counts, channel i at bits 24i+23..24i |
| pout_active_o | output | 4 | Pulse-output-active flags |
| home_o | output | 4 | Home-detected flags |

## Verification
Random sequences mix control writes carrying arbitrary nibbles, count bursts on random channel subsets, external reset edges and start pulses. This shows whether each channel keeps its level bits apart from its one-shot bits and from its neighbours' fields. Directed cases place a count edge in the same cycle as a software reset or an external reset, to expose the wrong priority. They also sample one cycle early and one cycle late around the third clock edge, to catch a wrong synchronizer depth. A second instance with 4-bit counters shares all the stimulus, so that wrap-around shows up without millions of edges.

// File: rtl/fastcnt_pkg.sv
package fastcnt_pkg;

    localparam int NIB_W = 4;

    // One channel's field of the control word, MSB first
    typedef struct packed {
        logic clr_stop;
        logic hrst_dis;
        logic cnt_dis;
        logic sw_rst;
    } ctl_nib_t;

    // Level bits kept between writes
    typedef struct packed {
        logic hrst_dis;
        logic cnt_dis;
    } lvl_t;

    function automatic int count_bits(logic [31:0] mask);
        int n = 0;
        for (int k = 0; k < 32; k++) n += int'(mask[k]);
        return n;
    endfunction

    // Position of channel ch among the channels that own an external reset
    function automatic int ext_index(logic [31:0] mask, int ch);
        int n = 0;
        for (int k = 0; k < 32; k++) if (k < ch && mask[k]) n++;
        return n;
    endfunction

endpackage

// File: rtl/fastcnt_edge.sv
module fastcnt_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // A detected edge lasts exactly one cycle (R3)
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/fastcnt_chan.sv
module fastcnt_chan import fastcnt_pkg::*; #(
    parameter int CW     = 24,
    parameter bit HAS_HW = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  ctl_nib_t      nib_i,
    input  lvl_t          lvl_i,
    input  logic          cnt_edge_i,
    input  logic          hw_edge_i,
    input  logic          start_i,
    output logic [CW-1:0] count_o,
    output logic          active_o,
    output logic          home_o
);
    logic [CW-1:0] count_q;
    logic          active_q, home_q;
    logic          zero_now, clr_now, hw_zero, home_hit;

    assign clr_now  = wr_i & nib_i.clr_stop;
    assign zero_now = wr_i & (nib_i.sw_rst | nib_i.clr_stop);
    assign hw_zero  = hw_edge_i & ~active_q & ~lvl_i.hrst_dis;
    assign home_hit = hw_edge_i & active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            active_q <= 1'b0;
            home_q   <= 1'b0;
        end else begin
            if (zero_now)                         count_q <= '0;
            else if (hw_zero)                     count_q <= '0;
            else if (cnt_edge_i && !lvl_i.cnt_dis) count_q <= count_q + CW'(1);

            if (clr_now) begin
                active_q <= 1'b0;
                home_q   <= 1'b0;
            end else begin
                if (start_i)  active_q <= 1'b1;
                if (home_hit) home_q   <= 1'b1;
            end
        end
    end

    assign count_o  = count_q;
    assign active_o = active_q;
    assign home_o   = home_q;

    p_swrst_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && nib_i.sw_rst) |=> count_q == '0);

    p_hold_when_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        (lvl_i.cnt_dis && !wr_i && !hw_edge_i) |=> $stable(count_q));

    p_clear_drops_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && nib_i.clr_stop) |=> (!active_q && !home_q && count_q == '0));

    p_home_needs_active_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(home_q) |-> $past(active_q));

    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        !zero_now |=> (count_q == $past(count_q) + CW'(1)) || $stable(count_q) || count_q == '0);

    if (!HAS_HW) begin : g_nohw
        p_no_home_r9: assert property (@(posedge clk) disable iff (rst) !home_q);
    end
endmodule

// File: rtl/fastcnt_ctrl.sv
module fastcnt_ctrl import fastcnt_pkg::*; #(
    parameter int             NCH     = 4,
    parameter int             CW      = 24,
    parameter logic [NCH-1:0] HW_MASK = 4'b0101,
    localparam int            NHW     = count_bits(32'(HW_MASK)),
    localparam int            WW      = NCH * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [WW-1:0]     ctl_wdata,
    input  logic [NCH-1:0]    cnt_in,
    input  logic [NHW-1:0]    ext_rst_in,
    input  logic [NCH-1:0]    pout_start,
    output logic [NCH*CW-1:0] count_o,
    output logic [NCH-1:0]    pout_active_o,
    output logic [NCH-1:0]    home_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ctl_nib_t nib;
        lvl_t     lvl_q;
        logic     cnt_edge, hw_edge;

        assign nib = ctl_wdata[i*NIB_W +: NIB_W];

        always_ff @(posedge clk) begin
            if (rst)         lvl_q <= '0;
            else if (ctl_we) lvl_q <= '{hrst_dis: nib.hrst_dis, cnt_dis: nib.cnt_dis};
        end

        fastcnt_edge #(.STAGES(2)) u_cnt_sync (
            .clk(clk), .rst(rst), .din(cnt_in[i]), .rise_o(cnt_edge)
        );

        if (HW_MASK[i]) begin : g_hw
            localparam int HI = ext_index(32'(HW_MASK), i);
            fastcnt_edge #(.STAGES(2)) u_hw_sync (
                .clk(clk), .rst(rst), .din(ext_rst_in[HI]), .rise_o(hw_edge)
            );
        end else begin : g_nohw
            assign hw_edge = 1'b0;
        end

        fastcnt_chan #(.CW(CW), .HAS_HW(HW_MASK[i])) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_i       (ctl_we),
            .nib_i      (nib),
            .lvl_i      (lvl_q),
            .cnt_edge_i (cnt_edge),
            .hw_edge_i  (hw_edge),
            .start_i    (pout_start[i]),
            .count_o    (count_o[i*CW +: CW]),
            .active_o   (pout_active_o[i]),
            .home_o     (home_o[i])
        );

        // Stored levels follow the last write (R1, R4, R6)
        p_level_latch_r1: assert property (@(posedge clk) disable iff (rst)
            ctl_we |=> lvl_q.cnt_dis == $past(ctl_wdata[i*NIB_W+1]));
    end
endmodule

// File: tb/fastcnt_ctrl_tb_top.sv
`timescale 1ns/1ps
module fastcnt_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [3:0]  cnt_in = '0;
    logic [1:0]  ext_rst_in = '0;
    logic [3:0]  pout_start = '0;
    logic [95:0] count_o;
    logic [15:0] count_w;
    logic [3:0]  act_o, act_w, home_o, home_w;

    int checks = 0;
    int errors = 0;

    int unsigned exp_cnt[4];
    bit exp_act[4], exp_home[4], exp_cdis[4], exp_hdis[4];

    always #2 clk = ~clk;

    fastcnt_ctrl dut_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cnt_in(cnt_in), .ext_rst_in(ext_rst_in), .pout_start(pout_start),
        .count_o(count_o), .pout_active_o(act_o), .home_o(home_o)
    );

    // Narrow counters share all stimulus to expose wrap-around (R3)
    fastcnt_ctrl #(.CW(4)) dut_w (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cnt_in(cnt_in), .ext_rst_in(ext_rst_in), .pout_start(pout_start),
        .count_o(count_w), .pout_active_o(act_w), .home_o(home_w)
    );

    task automatic check(string req, string what, int unsigned got, int unsigned exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 4; i++) begin
            check(req, $sformatf("ch%0d count", i), count_o[i*24 +: 24], exp_cnt[i] & 32'hFFFFFF);
            check(req, $sformatf("ch%0d narrow count", i), count_w[i*4 +: 4], exp_cnt[i] & 32'hF);
            check(req, $sformatf("ch%0d active", i), act_o[i], exp_act[i]);
            check(req, $sformatf("ch%0d home", i), home_o[i], exp_home[i]);
        end
    endtask

    function automatic void model_write(logic [15:0] w);
        for (int i = 0; i < 4; i++) begin
            logic [3:0] n = w[i*4 +: 4];
            if (n[0] || n[3]) exp_cnt[i] = 0;
            if (n[3]) begin exp_act[i] = 0; exp_home[i] = 0; end
            exp_cdis[i] = n[1];
            exp_hdis[i] = n[2];
        end
    endfunction

    task automatic do_write(logic [15:0] w, string req);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
        model_write(w);
        check_all(req);
    endtask

    task automatic do_count(logic [3:0] bits, string req);
        cnt_in = bits;
        repeat (4) @(negedge clk);
        cnt_in = '0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) if (bits[i] && !exp_cdis[i]) exp_cnt[i]++;
        check_all(req);
    endtask

    task automatic do_ext(logic [1:0] bits, string req);
        ext_rst_in = bits;
        repeat (4) @(negedge clk);
        ext_rst_in = '0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            int ch = k * 2;
            if (bits[k]) begin
                if (exp_act[ch])        exp_home[ch] = 1;
                else if (!exp_hdis[ch]) exp_cnt[ch] = 0;
            end
        end
        check_all(req);
    endtask

    task automatic do_start(logic [3:0] bits, string req);
        pout_start = bits;
        @(negedge clk);
        pout_start = '0;
        for (int i = 0; i < 4; i++) if (bits[i]) exp_act[i] = 1;
        check_all(req);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4; i++) begin
            exp_cnt[i] = 0; exp_act[i] = 0; exp_home[i] = 0; exp_cdis[i] = 0; exp_hdis[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R11");

        // R3: exact latency through synchronizer
        cnt_in = 4'b0001;
        @(negedge clk);
        @(negedge clk);
        check("R3", "ch0 before third edge", count_o[23:0], 0);
        @(negedge clk);
        check("R3", "ch0 after third edge", count_o[23:0], 1);
        cnt_in = '0;
        repeat (4) @(negedge clk);
        exp_cnt[0] = 1;
        check_all("R3");

        // R1: per-channel fields, only channel 2 reset
        do_count(4'b1111, "R3");
        do_count(4'b1110, "R3");
        do_write(16'h0100, "R1");
        do_write(16'h1000, "R2");
        do_count(4'b1111, "R2");

        // R4: disable is a level held across bursts
        do_write(16'h2222, "R4");
        do_count(4'b1111, "R4");
        do_count(4'b1111, "R4");
        do_write(16'h0000, "R4");
        do_count(4'b1111, "R4");

        // R5 / R6
        do_count(4'b0101, "R5");
        do_ext(2'b01, "R5");
        do_write(16'h4444, "R6");
        do_count(4'b1111, "R6");
        do_ext(2'b11, "R6");
        do_write(16'h0000, "R5");
        do_ext(2'b10, "R5");

        // R3 wrap: 20 edges on channel 1
        do_write(16'h1111, "R2");
        for (int k = 0; k < 20; k++) do_count(4'b0010, "R3");

        // R8 / R9 / R7
        do_start(4'b0101, "R8");
        do_count(4'b0101, "R9");
        do_ext(2'b11, "R9");
        do_write(16'h0800, "R7");
        do_write(16'h0009, "R7");
        do_start(4'b0010, "R8");
        ctl_we = 1'b1; ctl_wdata = 16'h0080; pout_start = 4'b0010;
        @(negedge clk);
        ctl_we = 1'b0; pout_start = '0;
        model_write(16'h0080);
        check("R8", "ch1 active after clear plus start", act_o[1], 0);
        check_all("R8");

        // R10: software reset coincides with count edge
        do_count(4'b1000, "R10");
        cnt_in = 4'b1000;
        @(negedge clk);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 16'h1000;
        @(negedge clk);
        ctl_we = 1'b0;
        check("R10", "ch3 after reset with edge", count_o[95:72], 0);
        cnt_in = '0;
        repeat (4) @(negedge clk);
        model_write(16'h1000);
        check_all("R10");

        // R10: external reset coincides with count edge
        do_count(4'b0001, "R10");
        cnt_in = 4'b0001; ext_rst_in = 2'b01;
        repeat (4) @(negedge clk);
        cnt_in = '0; ext_rst_in = '0;
        repeat (4) @(negedge clk);
        exp_cnt[0] = 0;
        check_all("R10");

        // Random mix
        for (int n = 0; n < 300; n++) begin
            case ($urandom % 5)
                0: do_write(16'($urandom), "R1");
                1, 2: do_count(4'($urandom), "R3");
                3: do_ext(2'($urandom), "R5");
                default: do_start(4'($urandom), "R8");
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule